// File: doc/BRIEF.md
# Infrared Transmit Pin Conditioner

This block drives one pad that feeds an infrared LED used for a serial link. A two-bit source code decides what reaches the pad: the UART transmit line, a general-purpose output bit, the real-energy pulse, or the reactive-energy pulse. The UART path has two optional shaping steps. It can complement the bit. It can also gate the bit with a carrier of roughly 38 kHz, whose high time is set by a two-bit duty code.

The carrier comes from a free-running divider. The clock frequency divided by `CARRIER_DIV` sets the carrier rate. When modulation is on, the LED pulses at the carrier rate for every zero bit, start bit included, and stays dark for every one bit. The three other sources go to the pad unchanged.

The pad drive is taken from a register, so changes to the controls never produce glitches at the pin. Every input is a plain level signal. The block has no flow control because the pad accepts a new value on every cycle.

Top module: `irtx_pin_cond`

## Requirements
- R1: Source code 1 drives `gpo_i` onto `pin_o`, and the pin shows the value one clock after it is sampled.
- R2: Source code 2 drives `wh_pulse_i` onto `pin_o`, and source code 3 drives `varh_pulse_i` onto `pin_o`, each with one clock of latency.
- R3: With source code 0, `mod_en_i` = 0 and `tx_invert_i` = 0, `pin_o` follows `uart_tx_i` one clock later.
- R4: With source code 0 and `tx_invert_i` = 1, the UART bit is complemented before it reaches the modulation stage or the pin.
- R5: With source code 0 and `mod_en_i` = 1, a shaped bit of 1 holds `pin_o` low, and a shaped bit of 0 puts the carrier on `pin_o`.
- R6: The carrier period is `CARRIER_DIV` clocks, and the high time is floor(`CARRIER_DIV` × f), where `duty_sel_i` 0 gives f = 1/2, 1 gives 3/8, 2 gives 1/4 and 3 gives 1/8.
- R7: For source codes 1, 2 and 3, `tx_invert_i`, `mod_en_i` and `duty_sel_i` have no effect on `pin_o`.
- R8: While `rst` is high, `pin_o` is 0 and the carrier divider is held at its start. After release, the first carrier clock is high, and the carrier stays high for the first high-time clocks of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 2 | Pad source: 0 UART, 1 GPO, 2 real pulse, 3 reactive pulse |
| uart_tx_i | input | 1 | UART serial output |
| gpo_i | input | 1 | General-purpose output bit |
| wh_pulse_i | input | 1 | Real-energy pulse |
| varh_pulse_i | input | 1 | Reactive-energy pulse |
| tx_invert_i | input | 1 | Complement the UART bit |
| mod_en_i | input | 1 | Gate the UART bit with the carrier |
| duty_sel_i | input | 2 | Carrier duty code |
| pin_o | output | 1 | Registered pad drive |

## Verification
The in-RTL assertions check the following on every cycle:
- The divider stays in range, steps by one and wraps at the end of the period.
- The carrier is never high outside the first half of the period.
- The pass-through of the alternate sources and the plain UART path each hold with one clock of latency.
- A shaped one bit under modulation always gives a dark pin.

Only the bench scenarios can show the exact high-time count for each duty code and the carrier phase just after reset. They also show that the shaping controls leave the alternate sources untouched, which the bench confirms by holding the pin level across a full carrier period.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  // Pad source codes; the numeric values are part of the control encoding.
  typedef enum logic [1:0] {
    SRC_UART = 2'd0,
    SRC_GPO  = 2'd1,
    SRC_WH   = 2'd2,
    SRC_VARH = 2'd3
  } src_sel_e;

  // Duty codes; eighths of the carrier period that are high = 4 - code.
  typedef enum logic [1:0] {
    DUTY_50   = 2'd0,
    DUTY_37P5 = 2'd1,
    DUTY_25   = 2'd2,
    DUTY_12P5 = 2'd3
  } duty_sel_e;

  localparam int unsigned DUTY_CODES = 4;
  localparam int unsigned DUTY_DENOM = 8;

  // Number of high clocks in one carrier period for a given duty code.
  function automatic int unsigned high_clocks(int unsigned div, int unsigned code);
    return (div * (DUTY_CODES - code)) / DUTY_DENOM;
  endfunction

endpackage

// File: rtl/irtx_carrier_gen.sv
module irtx_carrier_gen
  import irtx_pkg::*;
#(
  parameter int unsigned CARRIER_DIV = 6579
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] duty_i,
  output logic       carrier_o
);

  localparam int unsigned CW = (CARRIER_DIV > 1) ? $clog2(CARRIER_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CARRIER_DIV - 1);
  localparam logic [CW:0] HALF = (CW+1)'(CARRIER_DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   thr [DUTY_CODES];

  // One threshold per duty code, computed from the divisor.
  for (genvar g = 0; g < DUTY_CODES; g++) begin : g_thr
    localparam int unsigned HI = high_clocks(CARRIER_DIV, g);
    assign thr[g] = (CW+1)'(HI);
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign carrier_o = ({1'b0, cnt_q} < thr[duty_i]);

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_carrier_first_half_r6: assert property (@(posedge clk) disable iff (rst)
    carrier_o |-> ({1'b0, cnt_q} < HALF));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

endmodule

// File: rtl/irtx_uart_shaper.sv
module irtx_uart_shaper (
  input  logic uart_i,
  input  logic invert_i,
  input  logic mod_en_i,
  input  logic carrier_i,
  output logic line_o
);

  logic bit_s;

  // Inversion comes first, then the optional carrier gate.
  assign bit_s  = uart_i ^ invert_i;
  assign line_o = mod_en_i ? (~bit_s & carrier_i) : bit_s;

endmodule

// File: rtl/irtx_src_mux.sv
module irtx_src_mux
  import irtx_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       uart_line_i,
  input  logic       gpo_i,
  input  logic       wh_i,
  input  logic       varh_i,
  output logic       pad_d_o
);

  src_sel_e sel;
  assign sel = src_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SRC_GPO:  pad_d_o = gpo_i;
      SRC_WH:   pad_d_o = wh_i;
      SRC_VARH: pad_d_o = varh_i;
      default:  pad_d_o = uart_line_i;
    endcase
  end

endmodule

// File: rtl/irtx_pin_cond.sv
module irtx_pin_cond
  import irtx_pkg::*;
#(
  parameter int unsigned CARRIER_DIV = 6579
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel_i,
  input  logic       uart_tx_i,
  input  logic       gpo_i,
  input  logic       wh_pulse_i,
  input  logic       varh_pulse_i,
  input  logic       tx_invert_i,
  input  logic       mod_en_i,
  input  logic [1:0] duty_sel_i,
  output logic       pin_o
);

  logic carrier;
  logic uart_line;
  logic pad_d;
  logic pin_q;

  irtx_carrier_gen #(.CARRIER_DIV(CARRIER_DIV)) u_carrier (
    .clk       (clk),
    .rst       (rst),
    .duty_i    (duty_sel_i),
    .carrier_o (carrier)
  );

  irtx_uart_shaper u_shaper (
    .uart_i    (uart_tx_i),
    .invert_i  (tx_invert_i),
    .mod_en_i  (mod_en_i),
    .carrier_i (carrier),
    .line_o    (uart_line)
  );

  irtx_src_mux u_mux (
    .sel_i       (src_sel_i),
    .uart_line_i (uart_line),
    .gpo_i       (gpo_i),
    .wh_i        (wh_pulse_i),
    .varh_i      (varh_pulse_i),
    .pad_d_o     (pad_d)
  );

  // Registered pad drive: one flop between all controls and the pin.
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pad_d;
  end

  assign pin_o = pin_q;

  p_gpo_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'd1) |=> (pin_o == $past(gpo_i)));

  p_wh_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'd2) |=> (pin_o == $past(wh_pulse_i)));

  p_varh_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'd3) |=> (pin_o == $past(varh_pulse_i)));

  p_plain_uart_r3: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'd0 && !mod_en_i && !tx_invert_i) |=> (pin_o == $past(uart_tx_i)));

  p_invert_r4: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'd0 && !mod_en_i && tx_invert_i) |=> (pin_o != $past(uart_tx_i)));

  p_mark_dark_r5: assert property (@(posedge clk) disable iff (rst)
    (src_sel_i == 2'd0 && mod_en_i && (uart_tx_i != tx_invert_i)) |=> !pin_o);

  p_reset_low_r8: assert property (@(posedge clk)
    rst |=> !pin_o);

endmodule

// File: tb/irtx_pin_cond_tb_top.sv
module irtx_pin_cond_tb_top;

  localparam int unsigned DIV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_sel_i = 2'd0;
  logic       uart_tx_i = 1'b1;
  logic       gpo_i = 1'b0;
  logic       wh_pulse_i = 1'b0;
  logic       varh_pulse_i = 1'b0;
  logic       tx_invert_i = 1'b0;
  logic       mod_en_i = 1'b0;
  logic [1:0] duty_sel_i = 2'd0;
  logic       pin_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irtx_pin_cond #(.CARRIER_DIV(DIV)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .src_sel_i    (src_sel_i),
    .uart_tx_i    (uart_tx_i),
    .gpo_i        (gpo_i),
    .wh_pulse_i   (wh_pulse_i),
    .varh_pulse_i (varh_pulse_i),
    .tx_invert_i  (tx_invert_i),
    .mod_en_i     (mod_en_i),
    .duty_sel_i   (duty_sel_i),
    .pin_o        (pin_o)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs already applied at a negedge; let one edge register them.
  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Count high pad samples over one full carrier period.
  task automatic count_highs(output int highs);
    highs = 0;
    for (int i = 0; i < DIV; i++) begin
      if (pin_o) highs++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int highs;
    @(negedge clk);
    check("R8 pin low in reset", pin_o, 0);
    src_sel_i = 2'd0; mod_en_i = 1'b0; tx_invert_i = 1'b0; uart_tx_i = 1'b1;
    rst = 1'b0;
    settle();
    check("R8 plain idle after release", pin_o, 1);
    rst = 1'b1;
    settle();
    check("R8 reset forces pin low", pin_o, 0);
    // Carrier phase after release: high for 8 clocks, then low for 8.
    mod_en_i = 1'b1; duty_sel_i = 2'd0; uart_tx_i = 1'b0;
    rst = 1'b0;
    settle();
    highs = 0;
    for (int i = 0; i < DIV; i++) begin
      check("R8 carrier phase after reset", pin_o, (i < 8) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_gpo();
    src_sel_i = 2'd1; mod_en_i = 1'b0; tx_invert_i = 1'b0;
    gpo_i = 1'b1; uart_tx_i = 1'b0; settle();
    check("R1 gpo high", pin_o, 1);
    gpo_i = 1'b0; uart_tx_i = 1'b1; settle();
    check("R1 gpo low", pin_o, 0);
  endtask

  task automatic t_pulses();
    gpo_i = 1'b1;
    src_sel_i = 2'd2; wh_pulse_i = 1'b1; varh_pulse_i = 1'b0; settle();
    check("R2 real pulse high", pin_o, 1);
    wh_pulse_i = 1'b0; varh_pulse_i = 1'b1; settle();
    check("R2 real pulse low", pin_o, 0);
    src_sel_i = 2'd3; settle();
    check("R2 reactive pulse high", pin_o, 1);
    varh_pulse_i = 1'b0; wh_pulse_i = 1'b1; settle();
    check("R2 reactive pulse low", pin_o, 0);
  endtask

  task automatic t_uart_plain();
    src_sel_i = 2'd0; mod_en_i = 1'b0; tx_invert_i = 1'b0;
    uart_tx_i = 1'b0; settle();
    check("R3 uart zero", pin_o, 0);
    uart_tx_i = 1'b1; settle();
    check("R3 uart one", pin_o, 1);
  endtask

  task automatic t_invert();
    int highs;
    src_sel_i = 2'd0; mod_en_i = 1'b0; tx_invert_i = 1'b1;
    uart_tx_i = 1'b1; settle();
    check("R4 inverted one", pin_o, 0);
    uart_tx_i = 1'b0; settle();
    check("R4 inverted zero", pin_o, 1);
    // Inverted 0 becomes 1 before modulation: pad dark all period.
    mod_en_i = 1'b1; duty_sel_i = 2'd0; settle();
    count_highs(highs);
    check("R4 invert before modulation", highs, 0);
    tx_invert_i = 1'b0;
  endtask

  task automatic t_mod_duty();
    int highs;
    src_sel_i = 2'd0; mod_en_i = 1'b1; tx_invert_i = 1'b0;
    for (int d = 0; d < 4; d++) begin
      duty_sel_i = 2'(d); uart_tx_i = 1'b0; settle();
      count_highs(highs);
      check($sformatf("R6 duty code %0d high time", d), highs, (DIV * (4 - d)) / 8);
    end
    uart_tx_i = 1'b1; settle();
    count_highs(highs);
    check("R5 mark bit dark under modulation", highs, 0);
    uart_tx_i = 1'b0; duty_sel_i = 2'd2; settle();
    count_highs(highs);
    check("R5 space bit carries carrier", highs, DIV / 4);
  endtask

  task automatic t_alt_ignore();
    int highs;
    mod_en_i = 1'b1; tx_invert_i = 1'b1; duty_sel_i = 2'd3;
    src_sel_i = 2'd1; gpo_i = 1'b1; settle();
    count_highs(highs);
    check("R7 gpo ignores shaping (high)", highs, DIV);
    gpo_i = 1'b0; settle();
    count_highs(highs);
    check("R7 gpo ignores shaping (low)", highs, 0);
    src_sel_i = 2'd3; varh_pulse_i = 1'b1; settle();
    count_highs(highs);
    check("R7 reactive ignores shaping", highs, DIV);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_gpo();
    t_pulses();
    t_uart_plain();
    t_invert();
    t_mod_duty();
    t_alt_ignore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule